// File: doc/BRIEF.md
# Reloading Down-Count Interrupt Timer

This block is a single down-counting timer. Its only result is an interrupt flag. One control word holds four things: the reload count, a run enable, an interrupt enable and a sticky expiry flag. Software writes this word whole. A separate acknowledge strobe clears the flag and, when the run enable is set, restarts the count from the reload value. The counter moves only on cycles where the tick-enable input is high, so a prescaler outside the block sets the rate.

When the count runs out, the flag sets and the counter parks until it is acknowledged. The timer therefore restarts only under software control. The interrupt output is the flag gated by the interrupt enable, and it feeds an interrupt router. Field positions, widths and an optional output register are parameters, checked when the design elaborates.

Top module: `local_timer`

## Requirements
- R1: After reset the control word reads 0, the interrupt output is low and no count is in progress.
- R2: Control word layout: reload count in bits [27:0], run enable in bit 28, interrupt enable in bit 29, flag in bit 31. A control write stores every one of these bits as written, including the flag. Bit 30 always reads 0.
- R3: A control write with bit 28 set loads the reload count and starts counting. The count moves only on cycles where tick_en is high.
- R4: The flag (bit 31) sets at the clock edge of the reload-th tick after the count starts, and not earlier.
- R5: After expiry the counter halts. The flag stays set and further ticks change nothing until an acknowledge.
- R6: A control write with bit 28 clear stops any count in progress. Later ticks never set the flag.
- R7: An acknowledge clears the flag. If bit 28 is set, a full reload-length count restarts. If bit 28 is clear, the timer stays stopped.
- R8: irq_out is high exactly when bit 31 and bit 29 of the control word are both set.
- R9: A reload count of 0 with bit 28 set starts no count, and the flag never sets.
- R10: If an acknowledge coincides with the final tick, the acknowledge wins: the flag stays clear and a fresh count starts. If a control write coincides with expiry, the written word stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-step strobe from an external prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ack_we | input | 1 | Acknowledge strobe: clears flag, restarts if enabled |
| ctrl_rdata | output | 32 | Current control word |
| irq_out | output | 1 | Flag gated by interrupt enable |

## Verification
The hardest case to reach is an acknowledge landing in the same cycle as the final tick of a count. The ports show no count value, so that cycle must be found by counting ticks from a known load. The stimulus writes a small reload, gives exactly reload-minus-one ticks, and then raises tick_en and ack_we together. Another full reload of ticks must then be needed before the flag appears. The write-versus-expiry race is reached the same way, with a control write in place of the acknowledge.

// File: rtl/local_timer_pkg.sv
package local_timer_pkg;
   localparam int DEF_DATA_W    = 32;
   localparam int DEF_CNT_W     = 28;
   localparam int DEF_RUN_BIT   = 28;
   localparam int DEF_IRQEN_BIT = 29;
   localparam int DEF_FLAG_BIT  = 31;

   typedef enum logic {
      LTM_IDLE  = 1'b0,
      LTM_COUNT = 1'b1
   } ltm_state_e;
endpackage

// File: rtl/ltm_counter.sv
module ltm_counter
   import local_timer_pkg::*;
#(
   parameter int CNT_W = DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             stop,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   ltm_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;

   assign expire = (st_q == LTM_COUNT) && tick && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LTM_IDLE;
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         st_q  <= (load_val != '0) ? LTM_COUNT : LTM_IDLE;
      end else if (stop) begin
         st_q <= LTM_IDLE;
      end else if (st_q == LTM_COUNT && tick) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) st_q <= LTM_IDLE;
      end
   end
endmodule

// File: rtl/ltm_ctrl_reg.sv
module ltm_ctrl_reg
   import local_timer_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int CNT_W     = DEF_CNT_W,
   parameter int RUN_BIT   = DEF_RUN_BIT,
   parameter int IRQEN_BIT = DEF_IRQEN_BIT,
   parameter int FLAG_BIT  = DEF_FLAG_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic              expire,
   output logic [DATA_W-1:0] word,
   output logic              load,
   output logic [CNT_W-1:0]  reload,
   output logic              stop
);
   localparam logic [DATA_W-1:0] CNT_MASK = DATA_W'({CNT_W{1'b1}});
   localparam logic [DATA_W-1:0] WMASK    = CNT_MASK
                                          | (DATA_W'(1) << RUN_BIT)
                                          | (DATA_W'(1) << IRQEN_BIT)
                                          | (DATA_W'(1) << FLAG_BIT);

   logic [DATA_W-1:0] word_q, word_d;

   always_comb begin
      word_d = word_q;
      if (wr) word_d = wdata & WMASK;
      if (ack)                word_d[FLAG_BIT] = 1'b0;
      else if (expire && !wr) word_d[FLAG_BIT] = 1'b1;
   end

   assign load   = (wr || ack) && word_d[RUN_BIT];
   assign stop   = wr && !word_d[RUN_BIT];
   assign reload = word_d[CNT_W-1:0];
   assign word   = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end
endmodule

// File: rtl/ltm_irq_out.sv
module ltm_irq_out #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic irq_en,
   output logic irq
);
   logic raw;
   assign raw = flag & irq_en;

   if (REG_IRQ) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= raw;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = raw;
   end
endmodule

// File: rtl/local_timer.sv
module local_timer
   import local_timer_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int CNT_W     = DEF_CNT_W,
   parameter int RUN_BIT   = DEF_RUN_BIT,
   parameter int IRQEN_BIT = DEF_IRQEN_BIT,
   parameter int FLAG_BIT  = DEF_FLAG_BIT,
   parameter bit REG_IRQ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] ctrl_wdata,
   input  logic              ack_we,
   output logic [DATA_W-1:0] ctrl_rdata,
   output logic              irq_out
);
   if (CNT_W < 1 || CNT_W >= DATA_W) begin : g_bad_cnt
      $error("local_timer: CNT_W must lie in 1..DATA_W-1");
   end
   if (RUN_BIT < CNT_W || IRQEN_BIT < CNT_W || FLAG_BIT < CNT_W) begin : g_bad_pos
      $error("local_timer: control bits overlap the reload field");
   end
   if (RUN_BIT >= DATA_W || IRQEN_BIT >= DATA_W || FLAG_BIT >= DATA_W) begin : g_bad_rng
      $error("local_timer: control bit beyond word width");
   end
   if (RUN_BIT == IRQEN_BIT || RUN_BIT == FLAG_BIT || IRQEN_BIT == FLAG_BIT) begin : g_bad_dup
      $error("local_timer: control bits must be distinct");
   end

   logic             load, stop, expire;
   logic [CNT_W-1:0] reload;

   ltm_ctrl_reg #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .RUN_BIT(RUN_BIT),
      .IRQEN_BIT(IRQEN_BIT), .FLAG_BIT(FLAG_BIT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(ctrl_we), .wdata(ctrl_wdata),
      .ack(ack_we), .expire(expire), .word(ctrl_rdata),
      .load(load), .reload(reload), .stop(stop)
   );

   ltm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(load),
      .load_val(reload), .stop(stop), .expire(expire)
   );

   ltm_irq_out #(.REG_IRQ(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .flag(ctrl_rdata[FLAG_BIT]),
      .irq_en(ctrl_rdata[IRQEN_BIT]), .irq(irq_out)
   );
endmodule

module local_timer_chk #(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 28,
   parameter int RUN_BIT   = 28,
   parameter int IRQEN_BIT = 29,
   parameter int FLAG_BIT  = 31,
   parameter bit REG_IRQ   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              ctrl_we,
   input logic [DATA_W-1:0] ctrl_wdata,
   input logic              ack_we,
   input logic [DATA_W-1:0] ctrl_rdata,
   input logic              irq_out
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'({CNT_W{1'b1}})
                                      | (DATA_W'(1) << RUN_BIT)
                                      | (DATA_W'(1) << IRQEN_BIT)
                                      | (DATA_W'(1) << FLAG_BIT);
   logic [DATA_W-1:0] no_flag;
   assign no_flag = ~(DATA_W'(1) << FLAG_BIT);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl_rdata == '0 && !irq_out));

   // R2
   write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !ack_we) |=> (ctrl_rdata == ($past(ctrl_wdata) & KEEP)));

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> !ctrl_rdata[FLAG_BIT]);

   // R4
   flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_we && !ack_we && !ctrl_rdata[FLAG_BIT]) |=>
      (ctrl_rdata[FLAG_BIT] -> ($past(tick_en) && $past(ctrl_rdata[RUN_BIT]))));

   // R5
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_we && !ack_we) |=> ((ctrl_rdata & no_flag) == ($past(ctrl_rdata) & no_flag)));

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[FLAG_BIT] && !ctrl_we && !ack_we) |=> ctrl_rdata[FLAG_BIT]);

   if (!REG_IRQ) begin : g_irq_chk
      // R8
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out == (ctrl_rdata[FLAG_BIT] && ctrl_rdata[IRQEN_BIT]));
   end
endmodule

bind local_timer local_timer_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .RUN_BIT(RUN_BIT),
   .IRQEN_BIT(IRQEN_BIT), .FLAG_BIT(FLAG_BIT), .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_we(ctrl_we),
   .ctrl_wdata(ctrl_wdata), .ack_we(ack_we), .ctrl_rdata(ctrl_rdata),
   .irq_out(irq_out)
);

// File: tb/local_timer_tb.sv
module local_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        ack_we = 1'b0;
   logic [31:0] ctrl_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [31:0] RUN = 32'h1000_0000;
   localparam logic [31:0] IEN = 32'h2000_0000;
   localparam logic [31:0] FLG = 32'h8000_0000;

   localparam int NV = 7;
   localparam int V_RELOAD [NV] = '{5, 5, 5, 1, 3, 0, 4};
   localparam int V_IEN    [NV] = '{1, 1, 0, 1, 1, 1, 1};
   localparam int V_TICKS  [NV] = '{4, 5, 5, 1, 10, 6, 4};
   localparam int V_GAP    [NV] = '{0, 0, 2, 0, 1, 0, 3};
   localparam int V_FLAG   [NV] = '{0, 1, 1, 1, 1, 0, 1};

   always #2 clk = ~clk;

   local_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_we(ctrl_we),
      .ctrl_wdata(ctrl_wdata), .ack_we(ack_we), .ctrl_rdata(ctrl_rdata),
      .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [31:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); ack_we = 1'b1;
      @(negedge clk); ack_we = 1'b0;
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 word", ctrl_rdata, 32'h0);
      chk("R1 irq", {31'b0, irq_out}, 32'h0);
      rst_n = 1'b1;
      ticks(3, 0);
      chk("R1 no count", ctrl_rdata, 32'h0);

      // R3 R4 R8 R9 vector walk
      for (int v = 0; v < NV; v++) begin
         logic [31:0] w;
         w = RUN | (V_IEN[v] != 0 ? IEN : 32'h0) | 32'(V_RELOAD[v]);
         wr_ctrl(w);
         ticks(V_TICKS[v], V_GAP[v]);
         chk($sformatf("R4 flag v%0d", v), {31'b0, ctrl_rdata[31]}, 32'(V_FLAG[v]));
         chk($sformatf("R8 irq v%0d", v), {31'b0, irq_out}, 32'(V_FLAG[v] & V_IEN[v]));
         chk($sformatf("R3 reload v%0d", v), {4'b0, ctrl_rdata[27:0]}, 32'(V_RELOAD[v]));
         wr_ctrl(32'h0);
      end

      // R2 layout, bit 30 dropped
      wr_ctrl(32'hFFFF_FFFF);
      chk("R2 all ones", ctrl_rdata, 32'hBFFF_FFFF);
      wr_ctrl(FLG | IEN);
      chk("R2 flag by write", ctrl_rdata, FLG | IEN);
      chk("R8 irq on written flag", {31'b0, irq_out}, 32'h1);
      wr_ctrl(FLG);
      chk("R8 irq masked", {31'b0, irq_out}, 32'h0);

      // R7 ack with run enable clear stays stopped
      do_ack();
      chk("R7 ack clears", ctrl_rdata, 32'h0);
      ticks(4, 0);
      chk("R7 stays stopped", ctrl_rdata, 32'h0);

      // R5 halt after expiry, R7 restart on ack
      wr_ctrl(RUN | IEN | 32'd3);
      ticks(3, 0);
      chk("R5 expired", ctrl_rdata, FLG | RUN | IEN | 32'd3);
      ticks(7, 0);
      chk("R5 flag held", ctrl_rdata, FLG | RUN | IEN | 32'd3);
      do_ack();
      chk("R7 flag cleared", {31'b0, ctrl_rdata[31]}, 32'h0);
      ticks(2, 0);
      chk("R7 full reload before flag", {31'b0, ctrl_rdata[31]}, 32'h0);
      ticks(1, 0);
      chk("R7 restart expires", {31'b0, ctrl_rdata[31]}, 32'h1);

      // R6 stop by write with run enable clear
      wr_ctrl(RUN | 32'd5);
      ticks(2, 0);
      wr_ctrl(32'd5);
      ticks(10, 0);
      chk("R6 stopped", ctrl_rdata, 32'd5);

      // R3 rewrite mid-count restarts full count
      wr_ctrl(RUN | 32'd5);
      ticks(3, 0);
      wr_ctrl(RUN | 32'd5);
      ticks(4, 0);
      chk("R3 restart no flag", {31'b0, ctrl_rdata[31]}, 32'h0);
      ticks(1, 0);
      chk("R3 restart flag", {31'b0, ctrl_rdata[31]}, 32'h1);

      // R10 ack coincides with final tick
      wr_ctrl(RUN | 32'd4);
      ticks(3, 0);
      @(negedge clk); tick_en = 1'b1; ack_we = 1'b1;
      @(negedge clk); tick_en = 1'b0; ack_we = 1'b0;
      chk("R10 ack wins", {31'b0, ctrl_rdata[31]}, 32'h0);
      ticks(3, 0);
      chk("R10 fresh count pending", {31'b0, ctrl_rdata[31]}, 32'h0);
      ticks(1, 0);
      chk("R10 fresh count expires", {31'b0, ctrl_rdata[31]}, 32'h1);

      // R10 write coincides with expiry
      wr_ctrl(RUN | 32'd2);
      ticks(1, 0);
      @(negedge clk); tick_en = 1'b1; ctrl_we = 1'b1; ctrl_wdata = IEN | 32'd9;
      @(negedge clk); tick_en = 1'b0; ctrl_we = 1'b0;
      chk("R10 write wins", ctrl_rdata, IEN | 32'd9);

      // R1 reset mid-run
      wr_ctrl(RUN | IEN | 32'd2);
      ticks(1, 0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      ticks(3, 0);
      chk("R1 reset mid-run", ctrl_rdata, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule